// File: doc/BRIEF.md
# Cache Read Request/Wait Responder

This block sits between a processor's read port and a cache. It serves one read at a time over a plain request/wait bus. When the processor raises its request while the block is idle, the block stores the address in its own register and raises the stall line on the next clock. It then asks the cache, or the memory below it, for the word at the stored address through a lookup port. The block keeps the stall high for as long as that lookup takes.

When the lookup port acknowledges, the block registers the returned word. On the next cycle it drops the stall and, in that same cycle, raises a one-cycle data-valid strobe with the word on the return bus. It then spends one cycle going back to idle before it looks at the request line again. The processor may change or drop its address once the stall is up. The lookup always uses the stored copy.

Top module: `rd_handshake_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `cpu_wait`, `cpu_dvalid` and `lk_req` are all low.
- R2: If `cpu_req` is high at a clock edge while the block is idle (`cpu_wait` and `cpu_dvalid` both low), then from the next cycle `cpu_wait` and `lk_req` are high, and `lk_addr` equals the `cpu_addr` sampled at that edge.
- R3: While `lk_req` stays high, `lk_addr` holds its value, whatever `cpu_addr` does.
- R4: A clock edge with `lk_req` and `lk_ack` both high is followed by one cycle in which `cpu_dvalid` is high, `cpu_wait` is low, and `cpu_rdata` equals the `lk_data` sampled at that edge. `cpu_wait` and `cpu_dvalid` are never high together.
- R5: `cpu_dvalid` lasts exactly one cycle. In the cycle after it, `cpu_wait` is also low.
- R6: `cpu_req` held high through the data-valid cycle is not accepted at that cycle's edge. It is accepted at the edge of the idle cycle that follows, so `cpu_wait` rises again two cycles after the data-valid cycle.
- R7: `lk_req` stays high, and `cpu_wait` with it, from the cycle after acceptance until the cycle after `lk_ack`, however many cycles the lookup takes.
- R8: `lk_ack` arriving while `lk_req` is low has no effect: no `cpu_dvalid` follows, and `cpu_wait` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor read request |
| cpu_addr | input | AW | Processor read address |
| cpu_wait | output | 1 | Stall to the processor while a read is in flight |
| cpu_rdata | output | DW | Read data to the processor |
| cpu_dvalid | output | 1 | One-cycle strobe marking `cpu_rdata` valid |
| lk_req | output | 1 | Lookup request toward the cache or lower memory |
| lk_addr | output | AW | Stored address for the lookup |
| lk_ack | input | 1 | Lookup response strobe |
| lk_data | input | DW | Lookup response data |

## Verification
The hardest case to reach from the ports is a request that is still high during the data-valid cycle. The block must ignore that request for one cycle and then accept it. The bench holds `cpu_req` high through a whole read and checks that the stall is low in the turnaround cycle and high on the cycle after it. Other stimulus moves `cpu_addr` while the lookup is in progress, varies the lookup latency from one cycle to several, sends an acknowledge while no lookup is pending, and applies reset in the middle of a read.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } rhc_state_e;

    function automatic logic rhc_accept(rhc_state_e st, logic req);
        return (st == ST_IDLE) && req;
    endfunction

    function automatic logic rhc_capture(rhc_state_e st, logic ack);
        return (st == ST_BUSY) && ack;
    endfunction

endpackage

// File: rtl/rhc_hold_reg.sv
module rhc_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/rhc_fsm.sv
module rhc_fsm
    import rhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       ack,
    output rhc_state_e state,
    output logic       accept,
    output logic       capture
);
    rhc_state_e nxt;

    assign accept  = rhc_accept(state, req);
    assign capture = rhc_capture(state, ack);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)  nxt = ST_BUSY;
            ST_BUSY: if (capture) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/rd_handshake_ctrl.sv
module rd_handshake_ctrl
    import rhc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_wait,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_dvalid,
    output logic          lk_req,
    output logic [AW-1:0] lk_addr,
    input  logic          lk_ack,
    input  logic [DW-1:0] lk_data
);
    rhc_state_e state;
    logic       accept;
    logic       capture;

    rhc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (cpu_req),
        .ack     (lk_ack),
        .state   (state),
        .accept  (accept),
        .capture (capture)
    );

    rhc_hold_reg #(.W(AW)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .d    (cpu_addr),
        .q    (lk_addr)
    );

    rhc_hold_reg #(.W(DW)) u_data (
        .clk  (clk),
        .rst  (rst),
        .load (capture),
        .d    (lk_data),
        .q    (cpu_rdata)
    );

    assign cpu_wait   = (state == ST_BUSY);
    assign lk_req     = (state == ST_BUSY);
    assign cpu_dvalid = (state == ST_DONE);
endmodule

// File: rtl/rhc_checker.sv
module rhc_checker #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_req,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_wait,
    input logic [DW-1:0] cpu_rdata,
    input logic          cpu_dvalid,
    input logic          lk_req,
    input logic [AW-1:0] lk_addr,
    input logic          lk_ack,
    input logic [DW-1:0] lk_data
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!cpu_wait && !cpu_dvalid && !lk_req)); // R1

    AST_ACCEPT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_wait && !cpu_dvalid) |=> (cpu_wait && lk_req && lk_addr == $past(cpu_addr))); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lk_req && $past(lk_req)) |-> $stable(lk_addr)); // R3

    AST_RETURN_DATA: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_ack) |=> (cpu_dvalid && !cpu_wait && cpu_rdata == $past(lk_data))); // R4

    AST_NO_WAIT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wait && cpu_dvalid)); // R4

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        cpu_dvalid |=> (!cpu_dvalid && !cpu_wait)); // R5

    AST_LOOKUP_HELD: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_ack) |=> (lk_req && cpu_wait)); // R7

    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        (!lk_req && lk_ack) |=> !cpu_dvalid); // R8
endmodule

bind rd_handshake_ctrl rhc_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata), .cpu_dvalid(cpu_dvalid),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_ack(lk_ack), .lk_data(lk_data)
);

// File: tb/rd_handshake_ctrl_bench.sv
`timescale 1ns/1ps
module rd_handshake_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [3:0]    lat;
        logic          chg;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0010, 32'hDEADBEEF, 4'd1, 1'b0},
        '{16'h1234, 32'h01234567, 4'd3, 1'b1},
        '{16'hFFFF, 32'hFFFFFFFF, 4'd1, 1'b1},
        '{16'h0000, 32'h00000000, 4'd6, 1'b0},
        '{16'hA5A5, 32'h5A5A5A5A, 4'd9, 1'b1},
        '{16'h8001, 32'h80000001, 4'd2, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_wait;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_dvalid;
    logic          lk_req;
    logic [AW-1:0] lk_addr;
    logic          lk_ack = 1'b0;
    logic [DW-1:0] lk_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rd_handshake_ctrl #(.AW(AW), .DW(DW)) u_rd_handshake_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata), .cpu_dvalid(cpu_dvalid),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_ack(lk_ack), .lk_data(lk_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nxt;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        // R1: during reset
        nxt(); nxt();
        check(!cpu_wait && !cpu_dvalid && !lk_req, "R1 in reset", {29'd0, cpu_wait, cpu_dvalid, lk_req}, 32'd0);
        rst = 1'b0;
        nxt();
        check(!cpu_wait && !cpu_dvalid && !lk_req, "R1 after reset", {29'd0, cpu_wait, cpu_dvalid, lk_req}, 32'd0);

        // table-driven reads: R2 R3 R4 R5 R7
        foreach (VECS[i]) begin
            cpu_req  = 1'b1;
            cpu_addr = VECS[i].addr;
            nxt();
            check(cpu_wait && lk_req, "R2 wait up", {30'd0, cpu_wait, lk_req}, 32'd3);
            check(lk_addr == VECS[i].addr, "R2 addr", 32'(lk_addr), 32'(VECS[i].addr));
            cpu_req = 1'b0;
            if (VECS[i].chg) cpu_addr = ~VECS[i].addr;
            for (int k = 1; k < int'(VECS[i].lat); k++) begin
                nxt();
                check(cpu_wait && lk_req, "R7 held", {30'd0, cpu_wait, lk_req}, 32'd3);
                check(lk_addr == VECS[i].addr, "R3 addr held", 32'(lk_addr), 32'(VECS[i].addr));
            end
            lk_ack  = 1'b1;
            lk_data = VECS[i].data;
            nxt();
            lk_ack  = 1'b0;
            lk_data = ~VECS[i].data;
            check(cpu_dvalid && !cpu_wait, "R4 strobe", {30'd0, cpu_dvalid, cpu_wait}, 32'd2);
            check(cpu_rdata == VECS[i].data, "R4 data", cpu_rdata, VECS[i].data);
            nxt();
            check(!cpu_dvalid && !cpu_wait, "R5 one cycle", {30'd0, cpu_dvalid, cpu_wait}, 32'd0);
        end

        // R6: request held through the data-valid cycle
        cpu_req  = 1'b1;
        cpu_addr = 16'h0042;
        nxt();
        lk_ack = 1'b1; lk_data = 32'hCAFEF00D;
        nxt();
        lk_ack = 1'b0;
        check(cpu_dvalid, "R6 data cycle", {31'd0, cpu_dvalid}, 32'd1);
        cpu_addr = 16'h0043;
        nxt();
        check(!cpu_wait && !cpu_dvalid, "R6 not accepted in data cycle", {30'd0, cpu_wait, cpu_dvalid}, 32'd0);
        nxt();
        check(cpu_wait && lk_addr == 16'h0043, "R6 accepted after idle", {15'd0, cpu_wait, lk_addr}, {15'd0, 1'b1, 16'h0043});
        cpu_req = 1'b0;
        lk_ack = 1'b1; lk_data = 32'h11112222;
        nxt();
        lk_ack = 1'b0;
        check(cpu_rdata == 32'h11112222 && cpu_dvalid, "R4 second read", cpu_rdata, 32'h11112222);
        nxt();

        // R8: stray acknowledge while idle
        lk_ack = 1'b1; lk_data = 32'h99999999;
        nxt();
        lk_ack = 1'b0;
        check(!cpu_dvalid && !cpu_wait, "R8 stray ack", {30'd0, cpu_dvalid, cpu_wait}, 32'd0);
        check(cpu_rdata == 32'h11112222, "R8 data untouched", cpu_rdata, 32'h11112222);

        // R1: reset in the middle of a read
        cpu_req = 1'b1; cpu_addr = 16'h7777;
        nxt();
        cpu_req = 1'b0;
        check(cpu_wait, "R2 before mid reset", {31'd0, cpu_wait}, 32'd1);
        rst = 1'b1;
        nxt();
        check(!cpu_wait && !lk_req && !cpu_dvalid, "R1 mid-read reset", {29'd0, cpu_wait, lk_req, cpu_dvalid}, 32'd0);
        rst = 1'b0;
        nxt();
        check(!cpu_wait && !cpu_dvalid, "R1 idle after reset", {30'd0, cpu_wait, cpu_dvalid}, 32'd0);

        finish_run();
    end
endmodule